// File: doc/BRIEF.md
# Shifting Eight-Digit Hex Display Controller

This block is a bus slave that drives an eight-digit, multiplexed seven-segment display. Software writes one 32-bit command word per transfer. The command bits clear the digit buffer, shift it toward the more significant end, load a hex nibble into the least significant digit, or load a dark entry there. Text therefore scrolls in from the right, one digit per command, without any per-digit addressing.

Each of the eight entries holds a 4-bit value and a valid bit. A free-running scanner enables one digit at a time for `REFRESH_DIV` clocks each. While a digit is enabled, its entry is decoded to the segment lines. All display lines are active low.

A transfer is accepted when cycle and strobe are high and the address matches `BASE_ADDR` under `ADDR_MASK`. Reads are acknowledged and return zero.

Top module: `seg_shift_disp`

## Requirements
- R1: A transfer is selected when `wb_cyc` and `wb_stb` are high and `(wb_adr & ADDR_MASK) == (BASE_ADDR & ADDR_MASK)`. A selected transfer gets `wb_ack` high for exactly one cycle, in the cycle after the strobe is first sampled. An unselected transfer gets no ack and changes no digit.
- R2: `wb_dat_r` is always zero. A selected read is acknowledged and leaves every digit unchanged.
- R3: After synchronous reset (`rst` high), all eight digits are dark (`seg_n` = 8'hFF) and the scanner enables digit 0 (`an_n` = 8'hFE).
- R4: Command bit 16 (clear) makes all digits dark. When it is set, bits 24, 8 and 4 of the same word are ignored.
- R5: Command bit 24 (shift) without bit 8 moves entry i to entry i+1 for i = 0..6, discards entry 7, and makes entry 0 dark.
- R6: Bits 24 and 8 together shift as in R5, then store the nibble in bits 3..0 into entry 0 in the same command.
- R7: Bit 8 without bit 24 overwrites only entry 0 with the nibble in bits 3..0.
- R8: When bit 8 and bit 4 are both set, entry 0 becomes dark whatever the nibble holds. Bit 4 without bit 8 has no effect.
- R9: A lit digit shows its value on `seg_n[6:0]` = segments g..a, active low, using the standard glyphs. The glyphs are, as active-high g..a: 0:3F 1:06 2:5B 3:4F 4:66 5:6D 6:7D 7:07 8:7F 9:6F A:77 b:7C C:39 d:5E E:79 F:71. The decimal point `seg_n[7]` is always 1.
- R10: Exactly one bit of `an_n` is low at any time. The enabled digit advances 0,1,…,7 and wraps to 0, and each digit stays enabled for `REFRESH_DIV` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wb_cyc | input | 1 | Bus cycle valid |
| wb_stb | input | 1 | Bus strobe |
| wb_we | input | 1 | Write enable |
| wb_adr | input | 32 | Byte address |
| wb_dat_w | input | 32 | Command word |
| wb_dat_r | output | 32 | Read data, always zero |
| wb_ack | output | 1 | Transfer acknowledge |
| an_n | output | DIGITS | Digit enables, active low |
| seg_n | output | 8 | Segments a..g in bits 0..6 and decimal point in bit 7, active low |

## Verification
A wrong buffer entry shows only while its digit is enabled, so a fault can stay invisible for up to one full scan of `DIGITS*REFRESH_DIV` cycles. The bench therefore reads every digit after every command rather than only digit 0. A shift that drops or repeats an entry becomes visible at the next higher digit. A missed clear priority shows as a lit digit 0. A double-executed command shows as an entry moved two places or an ack lasting two cycles.

// File: rtl/seg_shift_disp.sv
module seg_shift_disp #(
  parameter logic [31:0] BASE_ADDR   = 32'h0000_0400,
  parameter logic [31:0] ADDR_MASK   = 32'hFFFF_FF00,
  parameter int          DIGITS      = 8,
  parameter int          REFRESH_DIV = 50000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wb_cyc,
  input  logic              wb_stb,
  input  logic              wb_we,
  input  logic [31:0]       wb_adr,
  input  logic [31:0]       wb_dat_w,
  output logic [31:0]       wb_dat_r,
  output logic              wb_ack,
  output logic [DIGITS-1:0] an_n,
  output logic [7:0]        seg_n
);
  localparam int IDX_W   = (DIGITS > 1) ? $clog2(DIGITS) : 1;
  localparam int CNT_W   = (REFRESH_DIV > 1) ? $clog2(REFRESH_DIV) : 1;
  localparam int B_SHIFT = 24;
  localparam int B_CLEAR = 16;
  localparam int B_WRITE = 8;
  localparam int B_OFF   = 4;

  logic [3:0]        val [DIGITS];
  logic [DIGITS-1:0] vld;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;

  wire sel    = wb_cyc && wb_stb && ((wb_adr & ADDR_MASK) == (BASE_ADDR & ADDR_MASK));
  wire cmd    = sel && wb_we && !wb_ack;
  wire do_clr = wb_dat_w[B_CLEAR];
  wire do_shf = wb_dat_w[B_SHIFT];
  wire do_wr  = wb_dat_w[B_WRITE];
  wire off    = wb_dat_w[B_OFF];
  wire [3:0] nib = wb_dat_w[3:0];

  logic unused_bits;
  assign unused_bits = ^{wb_dat_w[31:25], wb_dat_w[23:17], wb_dat_w[15:9], wb_dat_w[7:5]};

  assign wb_dat_r = '0;

  always_ff @(posedge clk) begin
    if (rst) wb_ack <= 1'b0;
    else     wb_ack <= sel && !wb_ack;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      for (int i = 0; i < DIGITS; i++) val[i] <= 4'h0;
    end else if (cmd) begin
      if (do_clr) begin
        vld <= '0;
      end else if (do_shf) begin
        for (int i = 1; i < DIGITS; i++) begin
          val[i] <= val[i-1];
          vld[i] <= vld[i-1];
        end
        val[0] <= nib;
        vld[0] <= do_wr && !off;
      end else if (do_wr) begin
        val[0] <= nib;
        vld[0] <= !off;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      idx <= '0;
    end else if (cnt == CNT_W'(REFRESH_DIV - 1)) begin
      cnt <= '0;
      idx <= (idx == IDX_W'(DIGITS - 1)) ? '0 : idx + 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  function automatic logic [6:0] glyph(input logic [3:0] v);
    case (v)
      4'h0: glyph = 7'h3F; 4'h1: glyph = 7'h06; 4'h2: glyph = 7'h5B; 4'h3: glyph = 7'h4F;
      4'h4: glyph = 7'h66; 4'h5: glyph = 7'h6D; 4'h6: glyph = 7'h7D; 4'h7: glyph = 7'h07;
      4'h8: glyph = 7'h7F; 4'h9: glyph = 7'h6F; 4'hA: glyph = 7'h77; 4'hB: glyph = 7'h7C;
      4'hC: glyph = 7'h39; 4'hD: glyph = 7'h5E; 4'hE: glyph = 7'h79; default: glyph = 7'h71;
    endcase
  endfunction

  assign an_n  = ~(DIGITS'(1) << idx);
  assign seg_n = vld[idx] ? {1'b1, ~glyph(val[idx])} : 8'hFF;

  AST_ACK_SINGLE:    assert property (@(posedge clk) disable iff (rst) wb_ack |=> !wb_ack); // R1
  AST_ACK_SELECTED:  assert property (@(posedge clk) disable iff (rst) wb_ack |-> $past(sel)); // R1
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst) (cmd && do_clr) |=> (vld == '0)); // R4
  AST_SHIFT_MOVES:   assert property (@(posedge clk) disable iff (rst)
    (cmd && do_shf && !do_clr) |=> (val[1] == $past(val[0]) && vld[1] == $past(vld[0]))); // R5
  AST_BLANK_WRITE:   assert property (@(posedge clk) disable iff (rst)
    (cmd && do_wr && off && !do_clr) |=> !vld[0]); // R8
  AST_ONE_ANODE:     assert property (@(posedge clk) disable iff (rst) $countones(~an_n) == 1); // R10
endmodule

// File: tb/tb_seg_shift_disp.sv
module tb_seg_shift_disp;
  localparam int DIV = 4;
  localparam logic [31:0] BASE = 32'h0000_0400;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wb_cyc = 1'b0, wb_stb = 1'b0, wb_we = 1'b0;
  logic [31:0] wb_adr = '0, wb_dat_w = '0;
  logic [31:0] wb_dat_r;
  logic wb_ack;
  logic [7:0] an_n, seg_n;

  int checks = 0;
  int errors = 0;

  logic [3:0] m_val [8];
  logic [7:0] m_vld;

  seg_shift_disp #(.BASE_ADDR(BASE), .ADDR_MASK(32'hFFFF_FF00), .DIGITS(8), .REFRESH_DIV(DIV)) dut (
    .clk(clk), .rst(rst), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
    .wb_adr(wb_adr), .wb_dat_w(wb_dat_w), .wb_dat_r(wb_dat_r), .wb_ack(wb_ack),
    .an_n(an_n), .seg_n(seg_n));

  always #10 clk = ~clk;

  // command word, expected entry 0 as {lit, value}
  localparam logic [36:0] VEC [15] = '{
    {32'h0000_010F, 5'h1F}, {32'h0100_0000, 5'h00}, {32'h0100_010A, 5'h1A},
    {32'h0100_010B, 5'h1B}, {32'h0100_010C, 5'h1C}, {32'h0100_0110, 5'h00},
    {32'h0000_0107, 5'h17}, {32'h0000_0013, 5'h17}, {32'h0100_0101, 5'h11},
    {32'h0100_0102, 5'h12}, {32'h0100_0103, 5'h13}, {32'h0000_0109, 5'h19},
    {32'h0101_011E, 5'h00}, {32'h0000_010D, 5'h1D}, {32'h0100_010E, 5'h1E}};

  function automatic logic [6:0] ref_glyph(input logic [3:0] v);
    logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                            7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
    return t[v];
  endfunction

  function automatic logic [7:0] ref_seg(input logic lit, input logic [3:0] v);
    return lit ? {1'b1, ~ref_glyph(v)} : 8'hFF;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_cmd(input logic [31:0] c);
    if (c[16]) m_vld = '0;
    else if (c[24]) begin
      for (int i = 7; i > 0; i--) begin m_val[i] = m_val[i-1]; m_vld[i] = m_vld[i-1]; end
      m_val[0] = c[3:0];
      m_vld[0] = c[8] && !c[4];
    end else if (c[8]) begin
      m_val[0] = c[3:0];
      m_vld[0] = !c[4];
    end
  endtask

  task automatic xfer(input logic we, input logic [31:0] adr, input logic [31:0] dat,
                      input logic exp_ack, input string req);
    @(negedge clk);
    wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = we; wb_adr = adr; wb_dat_w = dat;
    @(negedge clk);
    chk(wb_ack == exp_ack, req, "ack", 32'(wb_ack), 32'(exp_ack));
    if (exp_ack) chk(wb_dat_r == 32'h0, "R2", "dat_r", wb_dat_r, 32'h0);
    if (!exp_ack) begin
      @(negedge clk);
      chk(wb_ack == 1'b0, req, "ack unselected", 32'(wb_ack), 32'h0);
    end
    wb_cyc = 1'b0; wb_stb = 1'b0; wb_we = 1'b0;
    @(negedge clk);
    chk(wb_ack == 1'b0, "R1", "ack single cycle", 32'(wb_ack), 32'h0);
  endtask

  task automatic seg_at(input int k, output logic [7:0] s, output bit found);
    found = 0;
    s = 8'h00;
    for (int t = 0; t < 80 && !found; t++) begin
      @(negedge clk);
      if (an_n == ~(8'b1 << k)) begin found = 1; s = seg_n; end
    end
  endtask

  task automatic check_all(input string req);
    logic [7:0] s;
    bit f;
    for (int k = 0; k < 8; k++) begin
      seg_at(k, s, f);
      chk(f && s == ref_seg(m_vld[k], m_val[k]), req, $sformatf("digit %0d", k),
          32'(s), 32'(ref_seg(m_vld[k], m_val[k])));
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    string tag;
    logic [7:0] s;
    bit f;
    int dwell;
    m_vld = '0;
    for (int i = 0; i < 8; i++) m_val[i] = 4'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(an_n == 8'hFE, "R3", "an_n after reset", 32'(an_n), 32'hFE);
    chk(wb_ack == 1'b0, "R3", "ack after reset", 32'(wb_ack), 32'h0);
    check_all("R3");

    for (int r = 0; r < 15; r++) begin
      logic [31:0] c;
      c = VEC[r][36:5];
      if (c[16]) tag = "R4";
      else if (c[24] && c[8]) tag = "R6";
      else if (c[24]) tag = "R5";
      else if (c[8] && !c[4]) tag = "R7";
      else tag = "R8";
      xfer(1'b1, BASE + 32'h4, c, 1'b1, tag);
      model_cmd(c);
      seg_at(0, s, f);
      chk(f && s == ref_seg(VEC[r][4], VEC[r][3:0]), tag, $sformatf("row %0d digit 0", r),
          32'(s), 32'(ref_seg(VEC[r][4], VEC[r][3:0])));
      check_all(tag);
    end

    // R1: address outside the window is ignored
    xfer(1'b1, 32'h0000_0800, 32'h0001_0000, 1'b0, "R1");
    check_all("R1");
    // R2: read acknowledged, buffer untouched
    xfer(1'b0, BASE, 32'h0001_0000, 1'b1, "R2");
    check_all("R2");

    // R9: every glyph on digit 0
    for (int v = 0; v < 16; v++) begin
      xfer(1'b1, BASE, 32'h0000_0100 | 32'(v), 1'b1, "R9");
      seg_at(0, s, f);
      chk(f && s == {1'b1, ~ref_glyph(4'(v))}, "R9", $sformatf("glyph %0h", v),
          32'(s), 32'({1'b1, ~ref_glyph(4'(v))}));
    end

    // R10: dwell time and wrap
    seg_at(3, s, f);
    dwell = 1;
    @(negedge clk);
    while (an_n == 8'hF7 && dwell < 100) begin dwell++; @(negedge clk); end
    chk(dwell == DIV, "R10", "dwell cycles", 32'(dwell), 32'(DIV));
    chk(an_n == 8'hEF, "R10", "next digit", 32'(an_n), 32'hEF);
    seg_at(7, s, f);
    for (int t = 0; t < DIV; t++) @(negedge clk);
    chk(an_n == 8'hFE, "R10", "wrap to digit 0", 32'(an_n), 32'hFE);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule